// File: doc/BRIEF.md
# Programmable Vertical Frame Pulse Generator

This block produces a single programmable pulse once per vertical period for a display timing path. It keeps its own position counter that is re-zeroed at a fixed reference in every frame: after the leading edge of the vertical sync, it waits for the next horizontal sync leading edge (one line later), then takes the next enable-edge strobe as position zero. Two 12-bit position inputs choose where the output falls and where it rises again. The pulse therefore stays locked to the internal vertical counter and can sit anywhere in the frame.

When the programmable mode is switched off, the output instead carries the vertical sync as re-latched at each horizontal sync leading edge. All inputs are synchronous to `clk`, and all syncs are active-high, with the rising edge as the leading edge.

The reference search is a four-state machine. `ST_SEEK_VS` waits for the first vertical edge after clear. `ST_SEEK_LINE` waits one line. `ST_SEEK_ENB` waits for the strobe. `ST_TRACK` runs the locked count. The transitions are:
- `vs_edge`: from any state to `ST_SEEK_LINE`. It has priority over every other transition.
- `line_seen`: from `ST_SEEK_LINE` to `ST_SEEK_ENB`.
- `ref_taken`: from `ST_SEEK_ENB` to `ST_TRACK`. The counter is zeroed on this transition.

Top module: `vframe_pulse_gen`

## Requirements
- R1: A clock edge that samples `rst_n` low sets the output high, sets the position counter to zero and puts the machine in `ST_SEEK_VS`.
- R2: Position zero is the clock edge that samples the first `enb_edge_i` high after the first `hsync_i` rising edge that follows a `vsync_i` rising edge. A `vsync_i` rising edge always restarts this search, even in the same cycle as a strobe or hsync edge.
- R3: With `prog_en_i` high and the two positions different, the output goes low fall_pos_i+1 clock edges after the position-zero edge.
- R4: With `prog_en_i` high, the output goes high rise_pos_i+1 clock edges after the position-zero edge. When the fall position is below the rise position, the low phase therefore lasts rise_pos_i − fall_pos_i cycles per frame.
- R5: If the fall and rise positions are equal, the programmable output stays high.
- R6: The counter saturates at 4095 and does not wrap. A fall position of 4095 keeps the output low from that point until the rise position in the next frame.
- R7: After a clear and before the first `vsync_i` rising edge, the programmable output stays high whatever the position settings.
- R8: With `prog_en_i` low, the output equals the `vsync_i` value sampled at the most recent `hsync_i` rising edge. This value is registered one cycle after that edge. The selection follows `prog_en_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low clear |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| enb_edge_i | input | 1 | One-cycle strobe at each enable-pulse leading edge |
| prog_en_i | input | 1 | 1: programmable pulse, 0: latched vertical sync |
| fall_pos_i | input | 12 | Counter value at which the pulse falls |
| rise_pos_i | input | 12 | Counter value at which the pulse rises |
| vpulse_o | output | 1 | Vertical pulse output |

## Verification
The in-line assertions check the following on every cycle:
- the clear state;
- the `vs_edge` priority;
- the zeroing on `ref_taken`;
- saturation at the maximum count;
- the fall and rise updates at the compare points;
- the output holding high while unlocked;
- the vertical sync re-latch at each horizontal edge.

Only the bench's frame scenarios can show the absolute placement of the pulse relative to the sync pattern. The same holds for the per-frame low width in the normal, equal-position and saturated cases, and for the high time of the latched sync in disabled mode. The bench's behavioural model checks each of these every clock.

// File: rtl/vpg_pkg.sv
package vpg_pkg;

    typedef enum logic [1:0] {
        ST_SEEK_VS   = 2'd0,
        ST_SEEK_LINE = 2'd1,
        ST_SEEK_ENB  = 2'd2,
        ST_TRACK     = 2'd3
    } ref_state_t;

endpackage

// File: rtl/vpg_edge_det.sv
module vpg_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= sig_i[g];
            end
        end

        assign rise_o[g] = sig_i[g] & ~prev_q[g];
    end

endmodule

// File: rtl/vpg_ref_fsm.sv
module vpg_ref_fsm
    import vpg_pkg::*;
#(
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_rise_i,
    input  logic             vs_rise_i,
    input  logic             enb_edge_i,
    output logic [POS_W-1:0] pos_o,
    output logic             armed_o
);

    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    ref_state_t       state_q;
    ref_state_t       state_d;
    logic [POS_W-1:0] pos_q;
    logic             ref_taken;

    // Zero point: strobe seen while waiting for it, unless a new frame starts.
    assign ref_taken = (state_q == ST_SEEK_ENB) && enb_edge_i && !vs_rise_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEEK_VS;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (vs_rise_i) begin
            state_d = ST_SEEK_LINE;
        end else begin
            unique case (state_q)
                ST_SEEK_VS:   state_d = ST_SEEK_VS;
                ST_SEEK_LINE: if (hs_rise_i) state_d = ST_SEEK_ENB;
                ST_SEEK_ENB:  if (enb_edge_i) state_d = ST_TRACK;
                ST_TRACK:     state_d = ST_TRACK;
                default:      state_d = ST_SEEK_VS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (ref_taken) begin
            pos_q <= '0;
        end else if (pos_q != POS_MAX) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign pos_o   = pos_q;
    assign armed_o = (state_q != ST_SEEK_VS);

    // R1
    clear_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pos_q == '0) && (state_q == ST_SEEK_VS));

    // R2
    vs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise_i |=> (state_q == ST_SEEK_LINE));

    // R2
    ref_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEEK_ENB && enb_edge_i && !vs_rise_i)
        |=> (pos_q == '0) && (state_q == ST_TRACK));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == POS_MAX && !(state_q == ST_SEEK_ENB && enb_edge_i))
        |=> (pos_q == POS_MAX));

endmodule

// File: rtl/vpg_pulse_shaper.sv
module vpg_pulse_shaper #(
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [POS_W-1:0] fall_pos_i,
    input  logic [POS_W-1:0] rise_pos_i,
    input  logic             hs_rise_i,
    input  logic             vsync_i,
    input  logic             prog_en_i,
    output logic             pulse_o
);

    logic prog_q;
    logic vs_lat_q;
    logic hit_fall;
    logic hit_rise;

    assign hit_fall = armed_i && (pos_i == fall_pos_i) && (fall_pos_i != rise_pos_i);
    assign hit_rise = armed_i && (pos_i == rise_pos_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= 1'b1;
        end else if (hit_fall) begin
            prog_q <= 1'b0;
        end else if (hit_rise) begin
            prog_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_lat_q <= 1'b1;
        end else if (hs_rise_i) begin
            vs_lat_q <= vsync_i;
        end
    end

    assign pulse_o = prog_en_i ? prog_q : vs_lat_q;

    // R1
    clear_out_chk: assert property (@(posedge clk)
        !rst_n |=> prog_q && vs_lat_q);

    // R3
    fall_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && pos_i == fall_pos_i && fall_pos_i != rise_pos_i) |=> !prog_q);

    // R4
    rise_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && pos_i == rise_pos_i && fall_pos_i != pos_i) |=> prog_q);

    // R7
    unlocked_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_i && prog_q) |=> prog_q);

    // R8
    vs_relatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise_i |=> (vs_lat_q == $past(vsync_i)));

endmodule

// File: rtl/vframe_pulse_gen.sv
module vframe_pulse_gen #(
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_i,
    input  logic             vsync_i,
    input  logic             enb_edge_i,
    input  logic             prog_en_i,
    input  logic [POS_W-1:0] fall_pos_i,
    input  logic [POS_W-1:0] rise_pos_i,
    output logic             vpulse_o
);

    localparam int N_SYNC = 2;
    localparam int HS_IDX = 0;
    localparam int VS_IDX = 1;

    logic [N_SYNC-1:0] sync_in;
    logic [N_SYNC-1:0] sync_rise;
    logic [POS_W-1:0]  pos;
    logic              armed;

    assign sync_in[HS_IDX] = hsync_i;
    assign sync_in[VS_IDX] = vsync_i;

    vpg_edge_det #(.N(N_SYNC)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sync_in),
        .rise_o (sync_rise)
    );

    vpg_ref_fsm #(.POS_W(POS_W)) u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_rise_i  (sync_rise[HS_IDX]),
        .vs_rise_i  (sync_rise[VS_IDX]),
        .enb_edge_i (enb_edge_i),
        .pos_o      (pos),
        .armed_o    (armed)
    );

    vpg_pulse_shaper #(.POS_W(POS_W)) u_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed_i    (armed),
        .pos_i      (pos),
        .fall_pos_i (fall_pos_i),
        .rise_pos_i (rise_pos_i),
        .hs_rise_i  (sync_rise[HS_IDX]),
        .vsync_i    (vsync_i),
        .prog_en_i  (prog_en_i),
        .pulse_o    (vpulse_o)
    );

endmodule

// File: tb/test_vframe_pulse_gen.sv
module test_vframe_pulse_gen;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_LEN   = 64;
    localparam int LINES      = 70;
    localparam int FRAME      = LINE_LEN * LINES;
    localparam int ENB_OFF    = 20;
    localparam int HS_WIDTH   = 4;
    localparam int POS_MAX    = 4095;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic        enb = 1'b0;
    logic        prog_en = 1'b1;
    logic [11:0] fall_pos = 12'd0;
    logic [11:0] rise_pos = 12'd0;
    wire         vpulse;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference model state
    int m_ph = 0;
    int m_pos = 0;
    bit m_prog = 1'b1;
    bit m_vsl = 1'b1;
    bit m_hsp = 1'b0;
    bit m_vsp = 1'b0;

    vframe_pulse_gen i_vframe_pulse_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_i    (hsync),
        .vsync_i    (vsync),
        .enb_edge_i (enb),
        .prog_en_i  (prog_en),
        .fall_pos_i (fall_pos),
        .rise_pos_i (rise_pos),
        .vpulse_o   (vpulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        bit hs_r;
        bit vs_r;
        bit armed;
        int nph;
        int npos;
        hs_r  = hsync && !m_hsp;
        vs_r  = vsync && !m_vsp;
        armed = (m_ph != 0);
        if (!rst_n) begin
            m_prog = 1'b1; m_vsl = 1'b1; m_pos = 0; m_ph = 0;
            m_hsp = 1'b0; m_vsp = 1'b0;
        end else begin
            if (armed && m_pos == int'(fall_pos) && fall_pos != rise_pos) m_prog = 1'b0;
            else if (armed && m_pos == int'(rise_pos)) m_prog = 1'b1;
            if (hs_r) m_vsl = vsync;
            npos = (m_pos < POS_MAX) ? m_pos + 1 : m_pos;
            nph  = m_ph;
            if (vs_r) nph = 1;
            else if (m_ph == 1 && hs_r) nph = 2;
            else if (m_ph == 2 && enb) begin nph = 3; npos = 0; end
            m_pos = npos;
            m_ph  = nph;
            m_hsp = hsync;
            m_vsp = vsync;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit model_out();
        return prog_en ? m_prog : m_vsl;
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    // one cycle: sample and compare the previous result, then drive
    task automatic tick(input bit r, input bit h, input bit v, input bit e, output bit smp);
        @(negedge clk);
        smp = vpulse;
        check(cur_req, vpulse, model_out(), "per-cycle output vs model");
        rst_n = r; hsync = h; vsync = v; enb = e;
    endtask

    // one frame of sync pattern; counts low samples and first high->low sample index
    task automatic run_frame(input int vs_lines, input bit with_vs,
                             output int low_cnt, output int first_low);
        bit smp;
        bit prev;
        prev = 1'b1;
        low_cnt = 0;
        first_low = -1;
        for (int c = 0; c < FRAME; c++) begin
            int line = c / LINE_LEN;
            int col  = c % LINE_LEN;
            tick(1'b1, col < HS_WIDTH, with_vs && (line < vs_lines), col == ENB_OFF, smp);
            if (!smp) low_cnt++;
            if (!smp && prev && first_low < 0 && c > 0) first_low = c;
            prev = smp;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit smp;
        int lows;
        int first;

        // R1: reset state
        cur_req = "R1";
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, smp);
        check("R1", vpulse, 1, "output high in clear");

        // R7: syncs without vsync edges never arm the pulse
        cur_req = "R7";
        prog_en = 1'b1; fall_pos = 12'd5; rise_pos = 12'd20;
        run_frame(3, 1'b0, lows, first);
        check("R7", lows, 0, "low samples before first vsync edge");

        // R3 / R4: normal placement, fall below rise
        cur_req = "R3";
        fall_pos = 12'd100; rise_pos = 12'd300;
        for (int f = 0; f < 3; f++) run_frame(3, 1'b1, lows, first);
        check("R3", first, LINE_LEN + ENB_OFF + 2 + 100, "first low sample index");
        check("R4", lows, 200, "low width per frame");

        // R2: zero point placement with fall=0, rise=1
        cur_req = "R2";
        fall_pos = 12'd0; rise_pos = 12'd1;
        for (int f = 0; f < 2; f++) run_frame(3, 1'b1, lows, first);
        check("R2", first, LINE_LEN + ENB_OFF + 2, "low at reference point");
        check("R2", lows, 1, "single low cycle at reference");

        // R5: equal positions keep output high
        cur_req = "R5";
        fall_pos = 12'd250; rise_pos = 12'd250;
        for (int f = 0; f < 2; f++) run_frame(3, 1'b1, lows, first);
        check("R5", lows, 0, "equal positions low count");

        // R6: saturation, fall at the maximum count
        cur_req = "R6";
        fall_pos = 12'd4095; rise_pos = 12'd10;
        for (int f = 0; f < 3; f++) run_frame(3, 1'b1, lows, first);
        check("R6", lows, FRAME - 4085, "low samples with saturated counter");
        check("R6", vpulse, 0, "low held across frame boundary");

        // R1: clear in mid-run while output is low
        cur_req = "R1";
        tick(1'b0, 1'b0, 1'b0, 1'b0, smp);
        tick(1'b1, 1'b0, 1'b0, 1'b0, smp);
        check("R1", smp, 1, "output high after mid-run clear");

        // R8: disabled mode carries re-latched vsync
        cur_req = "R8";
        prog_en = 1'b0; fall_pos = 12'd100; rise_pos = 12'd300;
        for (int f = 0; f < 2; f++) run_frame(3, 1'b1, lows, first);
        check("R8", lows, FRAME - 3 * LINE_LEN, "latched vsync low count");
        prog_en = 1'b1;
        #1;
        check("R8", vpulse, m_prog, "mux follows enable at once");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule